// File: doc/BRIEF.md
# Burst Read Bus Master with Address Pipelining

This block is the processor-side engine that runs 64-bit read cycles on an external bus. An internal requester presents a byte address together with two qualifiers: whether the data may be cached and whether the requester can take a whole line. The master drives a one-clock address strobe, the quadword address and an active-low fill-intent line. It then collects the data the fabric returns, one quadword for each asserted ready.

Whether a cycle becomes a four-beat, 32-byte line fill or a single quadword is decided late, from the line-ok input sampled on the edge of the first accepted ready. The fabric returns the beats of a fill in the wrapped order that starts at the requested quadword. The master writes each beat into its own slot of a 256-bit line register and pulses a completion flag when the fourth beat lands. If the fabric asserts the early-address input together with the first ready of a fill, the master may strobe the next request while the current fill is still moving data. At most one cycle can be pending in this way.

Top module: `bmx_burst_reader`

## Requirements
- R1: With no cycle open, a request with `req_valid` high is accepted on the next rising edge (`req_ready` is high). `strobe_n` is then low for exactly the one following clock, with `bus_qaddr` equal to `req_addr[31:3]`.
- R2: `ready_n` is ignored on the edge that ends the strobe clock. From the next edge onward it is sampled on every rising edge, and each low sample is one beat.
- R3: `fill_intent_n` goes low together with the strobe when the request had both `req_cacheable` and `req_burst_ok` set. It stays low until that cycle ends, including across a pipelined follow-on fill. It is high when no open cycle carries fill intent.
- R4: `line_ok_n` counts only on the first beat. If it is low and fill intent was set, the cycle becomes a four-beat fill. Otherwise the cycle ends after that beat, and `word_done` pulses for one clock on the following clock with `word_data` holding the beat.
- R5: Beat k of a fill (k = 0..3) is quadword index `start XOR k`, where start is `req_addr[4:3]`. Quadword i lands in `line_data[64*i +: 64]`.
- R6: `line_done` pulses for one clock on the clock after the edge that captures the fourth beat, and `line_data` then holds the complete line. `line_ok_n` and `early_addr_n` have no effect on the second to fourth beats.
- R7: Any number of clocks with `ready_n` high may fall before or between beats. They add nothing and end nothing.
- R8: If `early_addr_n` is low on the first beat of a fill, `req_ready` is high from the next clock. A waiting request is then strobed before the current fill finishes. Without that, `req_ready` stays low while a cycle is open.
- R9: At most one pipelined cycle waits. `req_ready` is low while one is pending. Beats go to the oldest cycle, and the pending cycle takes its first beat on the edge right after the older fill completes.
- R10: After reset `strobe_n` and `fill_intent_n` are high, `req_ready` is high, and `word_done` and `line_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal read request present |
| req_ready | output | 1 | A request is taken on this edge if valid |
| req_addr | input | 32 | Byte address of the read |
| req_cacheable | input | 1 | Data may be cached |
| req_burst_ok | input | 1 | Requester accepts a full line |
| strobe_n | output | 1 | Active-low address strobe, one clock per cycle |
| fill_intent_n | output | 1 | Active-low line-fill intent |
| bus_qaddr | output | 29 | Quadword address of the latest cycle |
| ready_n | input | 1 | Active-low beat ready from the fabric |
| line_ok_n | input | 1 | Active-low line-fill permission, used on the first beat |
| early_addr_n | input | 1 | Active-low request for the next address, used on the first beat |
| rd_data | input | 64 | Returned quadword |
| word_done | output | 1 | Single transfer finished |
| word_data | output | 64 | Data of the single transfer |
| line_done | output | 1 | Four-beat fill finished |
| line_data | output | 256 | Assembled line, quadword i at bits 64*i |

## Verification
The hardest state to reach from the ports is two open cycles at once: an older fill in mid data phase and a younger one already strobed. The hand-over between them, where the younger cycle must take the very next beat, is part of the same difficulty. A directed sequence gets there. It holds the second request on the request port while the first fill is strobed, and asserts early-address with the first beat. It then keeps driving beats through the clock in which the second strobe appears. Its first beat comes right after the fourth beat of the older fill, with no idle clock. A separate case drives a bogus ready during the strobe clock to show that the master does not count it.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    localparam int unsigned BMX_BEATS = 4;
    localparam int unsigned BMX_QW_W  = $clog2(BMX_BEATS);

    typedef struct packed {
        logic                valid;
        logic                fresh;      // strobe is out this clock
        logic                want_fill;  // fill intent driven with strobe
        logic                first_seen; // first beat taken, fill decided
        logic                early_ok;   // next address may be issued
        logic [BMX_QW_W-1:0] beat;
        logic [BMX_QW_W-1:0] start_qw;
    } slot_t;
endpackage

// File: rtl/bmx_strobe_drv.sv
module bmx_strobe_drv #(
    parameter int unsigned NSLOT = 2
) (
    input  logic [NSLOT-1:0] slot_valid,
    input  logic [NSLOT-1:0] slot_fresh,
    input  logic [NSLOT-1:0] slot_want,
    output logic             strobe_n,
    output logic             fill_intent_n
);
    logic [NSLOT-1:0] strobing;
    logic [NSLOT-1:0] filling;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign strobing[i] = slot_valid[i] & slot_fresh[i];
        assign filling[i]  = slot_valid[i] & slot_want[i];
    end

    assign strobe_n      = ~|strobing;
    assign fill_intent_n = ~|filling;
endmodule

// File: rtl/bmx_line_buf.sv
module bmx_line_buf #(
    parameter int unsigned DW    = 64,
    parameter int unsigned BEATS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic [$clog2(BEATS)-1:0] cap_idx,
    input  logic [DW-1:0]         cap_data,
    output logic [DW*BEATS-1:0]   line_q
);
    localparam int unsigned IW = $clog2(BEATS);

    for (genvar i = 0; i < BEATS; i++) begin : g_lane
        logic [DW-1:0] lane_d;
        logic [DW-1:0] lane_q;

        always_comb begin
            lane_d = lane_q;
            if (cap_en && (cap_idx == IW'(i))) begin
                lane_d = cap_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign line_q[i*DW +: DW] = lane_q;
    end
endmodule

// File: rtl/bmx_burst_reader.sv
module bmx_burst_reader
    import bmx_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [AW-1:0]             req_addr,
    input  logic                      req_cacheable,
    input  logic                      req_burst_ok,
    output logic                      strobe_n,
    output logic                      fill_intent_n,
    output logic [AW-$clog2(DW/8)-1:0] bus_qaddr,
    input  logic                      ready_n,
    input  logic                      line_ok_n,
    input  logic                      early_addr_n,
    input  logic [DW-1:0]             rd_data,
    output logic                      word_done,
    output logic [DW-1:0]             word_data,
    output logic                      line_done,
    output logic [DW*BMX_BEATS-1:0]   line_data
);
    localparam int unsigned QB     = $clog2(DW/8);
    localparam int unsigned QA_W   = AW - QB;
    localparam int unsigned NSLOT  = 2;
    localparam int unsigned LAST_B = BMX_BEATS - 1;

    typedef struct packed {
        slot_t           s0;  // oldest open cycle, owns the data phase
        slot_t           s1;  // pipelined cycle waiting for data
        logic [QA_W-1:0] addr;
        logic            word_done;
        logic [DW-1:0]   word_data;
        logic            line_done;
    } state_t;

    state_t              st_d;
    state_t              st_q;
    slot_t               cur;
    slot_t               nxt0;
    slot_t               nxt1;
    slot_t               new_slot;
    logic                take;
    logic                retire;
    logic                accept;
    logic                cap_en;
    logic [BMX_QW_W-1:0] cap_idx;

    assign req_ready = !st_q.s0.valid || (st_q.s0.early_ok && !st_q.s1.valid);
    assign accept    = req_valid && req_ready;
    assign take      = !ready_n && st_q.s0.valid && !st_q.s0.fresh;

    always_comb begin
        st_d           = st_q;
        st_d.word_done = 1'b0;
        st_d.line_done = 1'b0;
        cur            = st_q.s0;
        retire         = 1'b0;
        cap_en         = 1'b0;
        cap_idx        = st_q.s0.start_qw ^ st_q.s0.beat;

        // data phase of the oldest cycle
        if (take) begin
            if (!cur.first_seen) begin
                if (cur.want_fill && !line_ok_n) begin
                    cur.first_seen = 1'b1;
                    cur.early_ok   = !early_addr_n;
                    cap_en         = 1'b1;
                    cur.beat       = cur.beat + 1'b1;
                end else begin
                    retire         = 1'b1;
                    st_d.word_done = 1'b1;
                    st_d.word_data = rd_data;
                end
            end else begin
                cap_en = 1'b1;
                if (cur.beat == BMX_QW_W'(LAST_B)) begin
                    retire         = 1'b1;
                    st_d.line_done = 1'b1;
                end
                cur.beat = cur.beat + 1'b1;
            end
        end

        // strobe lasts one clock for every slot
        cur.fresh = 1'b0;
        nxt1      = st_q.s1;
        nxt1.fresh = 1'b0;
        if (retire) begin
            nxt0 = nxt1;
            nxt1 = '0;
        end else begin
            nxt0 = cur;
        end

        // issue a new cycle
        new_slot            = '0;
        new_slot.valid      = 1'b1;
        new_slot.fresh      = 1'b1;
        new_slot.want_fill  = req_cacheable && req_burst_ok;
        new_slot.start_qw   = req_addr[QB +: BMX_QW_W];
        if (accept) begin
            st_d.addr = req_addr[AW-1:QB];
            if (!nxt0.valid) begin
                nxt0 = new_slot;
            end else begin
                nxt1 = new_slot;
            end
        end

        st_d.s0 = nxt0;
        st_d.s1 = nxt1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bmx_strobe_drv #(
        .NSLOT(NSLOT)
    ) u_strobe (
        .slot_valid   ({st_q.s1.valid,     st_q.s0.valid}),
        .slot_fresh   ({st_q.s1.fresh,     st_q.s0.fresh}),
        .slot_want    ({st_q.s1.want_fill, st_q.s0.want_fill}),
        .strobe_n     (strobe_n),
        .fill_intent_n(fill_intent_n)
    );

    bmx_line_buf #(
        .DW   (DW),
        .BEATS(BMX_BEATS)
    ) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .cap_data(rd_data),
        .line_q  (line_data)
    );

    assign bus_qaddr = st_q.addr;
    assign word_done = st_q.word_done;
    assign word_data = st_q.word_data;
    assign line_done = st_q.line_done;
endmodule

// File: rtl/bmx_burst_reader_chk.sv
module bmx_burst_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_cacheable,
    input logic req_burst_ok,
    input logic strobe_n,
    input logic fill_intent_n,
    input logic word_done,
    input logic line_done
);
    // R1
    strobe_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> strobe_n);

    // R1
    accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !strobe_n);

    // R3
    fill_intent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cacheable && req_burst_ok) |=> !fill_intent_n);

    // R9
    one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> !req_ready);

    // R6
    line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    // R4
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_done && word_done));
endmodule

bind bmx_burst_reader bmx_burst_reader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_cacheable(req_cacheable),
    .req_burst_ok (req_burst_ok),
    .strobe_n     (strobe_n),
    .fill_intent_n(fill_intent_n),
    .word_done    (word_done),
    .line_done    (line_done)
);

// File: tb/bmx_burst_reader_test.sv
module bmx_burst_reader_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_cacheable = 1'b0;
    logic         req_burst_ok = 1'b0;
    logic         strobe_n;
    logic         fill_intent_n;
    logic [28:0]  bus_qaddr;
    logic         ready_n = 1'b1;
    logic         line_ok_n = 1'b1;
    logic         early_addr_n = 1'b1;
    logic [63:0]  rd_data = '0;
    logic         word_done;
    logic [63:0]  word_data;
    logic         line_done;
    logic [255:0] line_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bmx_burst_reader uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cacheable(req_cacheable), .req_burst_ok(req_burst_ok),
        .strobe_n(strobe_n), .fill_intent_n(fill_intent_n), .bus_qaddr(bus_qaddr),
        .ready_n(ready_n), .line_ok_n(line_ok_n), .early_addr_n(early_addr_n),
        .rd_data(rd_data), .word_done(word_done), .word_data(word_data),
        .line_done(line_done), .line_data(line_data)
    );

    // {start_qw[1:0], cacheable, burst_ok, line_ok, waits[1:0], early, seed[7:0]}
    localparam logic [15:0] VECS [0:7] = '{
        {2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 8'h11},
        {2'd1, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 8'h22},
        {2'd2, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 8'h33},
        {2'd3, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 8'h44},
        {2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 8'h55},
        {2'd1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 8'h66},
        {2'd3, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 8'h77},
        {2'd0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 8'h88}
    };

    function automatic logic [63:0] dat(input logic [7:0] s, input int bb);
        return {s, 8'(bb), 16'hBEEF, s ^ 8'hFF, 8'(bb), 16'h1234};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_beat(input logic [63:0] d, input logic lok, input logic ea);
        ready_n = 1'b0; rd_data = d; line_ok_n = lok; early_addr_n = ea;
    endtask

    task automatic idle_bus();
        ready_n = 1'b1; line_ok_n = 1'b1; early_addr_n = 1'b1; rd_data = 64'hDEAD_0000_DEAD_0000;
    endtask

    task automatic do_cycle(input logic [31:0] a, input logic c, input logic b, input logic k,
                            input logic na, input int w, input logic [7:0] seed, input bit glitch);
        logic         fill;
        logic [255:0] exp_line;
        int           nb;
        int           neg;
        fill = c & b & k;
        nb = fill ? 4 : 1;
        exp_line = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cacheable = c; req_burst_ok = b;
        chk(req_ready == 1'b1, "R1 ready when idle", 256'(req_ready), 256'(1));
        @(negedge clk);
        req_valid = 1'b0;
        chk(strobe_n == 1'b0 && bus_qaddr == a[31:3], "R1 strobe with address",
            256'({strobe_n, bus_qaddr}), 256'({1'b0, a[31:3]}));
        chk(fill_intent_n == !(c & b), "R3 fill intent with strobe",
            256'(fill_intent_n), 256'(!(c & b)));
        if (glitch) begin
            drive_beat(64'hBAD0_BAD0_BAD0_BAD0, 1'b0, 1'b1);  // R2: must be ignored
        end
        neg = 0;
        for (int bb = 0; bb < nb; bb++) begin
            for (int i = 0; i < w; i++) begin
                @(negedge clk);
                idle_bus();
                if (neg == 0) chk(strobe_n == 1'b1, "R1 strobe one clock", 256'(strobe_n), 256'(1));
                neg++;
                chk(line_done == 1'b0 && word_done == 1'b0, "R7 wait adds nothing",
                    256'({line_done, word_done}), 256'(0));
            end
            @(negedge clk);
            if (neg == 0) chk(strobe_n == 1'b1, "R1 strobe one clock", 256'(strobe_n), 256'(1));
            neg++;
            chk(fill_intent_n == !(c & b), "R3 fill intent held", 256'(fill_intent_n), 256'(!(c & b)));
            // later beats drive the opposite line-ok and an early request: R6 no effect
            drive_beat(dat(seed, bb), (bb == 0) ? !k : k, (bb == 0) ? !na : 1'b0);
            exp_line[64*(a[4:3] ^ 2'(bb)) +: 64] = dat(seed, bb);
        end
        @(negedge clk);
        idle_bus();
        if (fill) begin
            chk(line_done == 1'b1, "R6 line done pulse", 256'(line_done), 256'(1));
            chk(line_data == exp_line, "R5 wrapped line order", line_data, exp_line);
            chk(word_done == 1'b0, "R4 no single on fill", 256'(word_done), 256'(0));
        end else begin
            chk(word_done == 1'b1 && word_data == dat(seed, 0), "R4 single transfer",
                256'({word_done, word_data}), 256'({1'b1, dat(seed, 0)}));
            chk(line_done == 1'b0, "R4 no line on single", 256'(line_done), 256'(0));
        end
        @(negedge clk);
        chk(line_done == 1'b0 && word_done == 1'b0 && strobe_n == 1'b1 && fill_intent_n == 1'b1,
            "R6 pulse ends, bus idle", 256'({line_done, word_done, strobe_n, fill_intent_n}), 256'(4'b0011));
    endtask

    initial begin : main
        logic [255:0] exp_a;
        logic [255:0] exp_b;
        idle_bus();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(strobe_n == 1'b1 && fill_intent_n == 1'b1, "R10 bus idle in reset",
            256'({strobe_n, fill_intent_n}), 256'(2'b11));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && word_done == 1'b0 && line_done == 1'b0, "R10 after reset",
            256'({req_ready, word_done, line_done}), 256'(3'b100));

        // vector table
        for (int v = 0; v < 8; v++) begin
            do_cycle({20'hABCD0, 7'(v), VECS[v][15:14], 3'b000}, VECS[v][13], VECS[v][12],
                     VECS[v][11], VECS[v][8], int'(VECS[v][10:9]), VECS[v][7:0], 1'b0);
        end

        // R2: ready during the strobe clock is not a beat
        do_cycle(32'h0000_1018, 1'b1, 1'b1, 1'b1, 1'b0, 1, 8'h99, 1'b1);

        // R8 / R9: pipelined second fill
        exp_a = '0; exp_b = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h1000_0050; req_cacheable = 1'b1; req_burst_ok = 1'b1;
        @(negedge clk);                                           // strobe of A
        req_addr = 32'h2000_0008;                                 // B waits
        chk(req_ready == 1'b0, "R8 no issue while strobing", 256'(req_ready), 256'(0));
        @(negedge clk);
        drive_beat(dat(8'hA0, 0), 1'b0, 1'b0);                    // A beat 0 with early
        exp_a[64*(2^0) +: 64] = dat(8'hA0, 0);
        chk(req_ready == 1'b0, "R8 no early issue before grant", 256'(req_ready), 256'(0));
        @(negedge clk);
        idle_bus();
        chk(req_ready == 1'b1 && strobe_n == 1'b1, "R8 ready after early grant",
            256'({req_ready, strobe_n}), 256'(2'b11));
        @(negedge clk);                                           // strobe of B
        req_valid = 1'b0;
        chk(strobe_n == 1'b0 && bus_qaddr == 29'(32'h2000_0008 >> 3), "R8 overlapped strobe",
            256'({strobe_n, bus_qaddr}), 256'({1'b0, 29'(32'h2000_0008 >> 3)}));
        chk(fill_intent_n == 1'b0, "R3 intent across pipelined fill", 256'(fill_intent_n), 256'(0));
        chk(req_ready == 1'b0, "R9 one pending only", 256'(req_ready), 256'(0));
        drive_beat(dat(8'hA0, 1), 1'b1, 1'b0);
        exp_a[64*(2^1) +: 64] = dat(8'hA0, 1);
        @(negedge clk);
        chk(strobe_n == 1'b1, "R1 overlapped strobe one clock", 256'(strobe_n), 256'(1));
        drive_beat(dat(8'hA0, 2), 1'b1, 1'b1);
        exp_a[64*(2^2) +: 64] = dat(8'hA0, 2);
        @(negedge clk);
        drive_beat(dat(8'hA0, 3), 1'b1, 1'b1);
        exp_a[64*(2^3) +: 64] = dat(8'hA0, 3);
        @(negedge clk);
        chk(line_done == 1'b1 && line_data == exp_a, "R9 oldest fill gets beats first", line_data, exp_a);
        chk(fill_intent_n == 1'b0, "R3 intent held for pending fill", 256'(fill_intent_n), 256'(0));
        for (int bb = 0; bb < 4; bb++) begin
            drive_beat(dat(8'hB0, bb), (bb == 0) ? 1'b0 : 1'b1, 1'b1);
            exp_b[64*(1 ^ bb) +: 64] = dat(8'hB0, bb);
            @(negedge clk);
            if (bb == 0) chk(line_done == 1'b0, "R6 single clock pulse", 256'(line_done), 256'(0));
        end
        idle_bus();
        chk(line_done == 1'b1 && line_data == exp_b, "R9 pending fill takes next beat", line_data, exp_b);
        @(negedge clk);
        chk(fill_intent_n == 1'b1 && req_ready == 1'b1, "R3 intent released",
            256'({fill_intent_n, req_ready}), 256'(2'b11));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule